// File: doc/BRIEF.md
# Privilege Trap Checker

This block sits beside the decode or rename stage of an in-order or out-of-order core and decides, in the same cycle, whether the instruction being examined must raise an illegal-instruction exception because of the current privilege state. It takes the decoded instruction attributes (instruction class, whether floating-point registers are read or written, the CSR address, the CSR operation kind and whether its source operand is zero), together with the hart's privilege level and the floating-point enable and wait-timeout fields of the machine status register.

The decision merges four rules: floating-point access is refused while the floating-point unit is switched off, a wait-for-interrupt below machine mode is refused while wait-timeout is set, writes to read-only CSRs are refused, and CSR accesses from a privilege level below the one encoded in the CSR address are refused. Any refusal reports the illegal-instruction cause. The block is purely combinational; there is no state and no clock.

Top module: `priv_trap_chk`

## Requirements
- R1: When `fp_regs_i` is 1 and `fs_i` is 2'b00, `trap_o` is 1; with `fs_i` of 2'b01, 2'b10 or 2'b11 floating-point register use alone does not trap.
- R2: A CSR-class instruction (`op_class_i` = 2'd1) addressing 0x001, 0x002 or 0x003 traps when `fs_i` is 2'b00, whether it reads or writes; with any other `fs_i` value these addresses obey only R4 to R6.
- R3: A WFI-class instruction (`op_class_i` = 2'd2) traps when `tw_i` is 1 and `priv_i` is below 2'b11; it does not trap when `tw_i` is 0 or `priv_i` is 2'b11.
- R4: A CSR write to an address whose bits [11:10] are 2'b11 traps; a write is `csr_op_i` = 2'd1 (swap) or 2'd0 (treated as swap), or `csr_op_i` = 2'd2 (set) or 2'd3 (clear) with `csr_src_zero_i` = 0.
- R5: Set or clear (`csr_op_i` 2'd2 or 2'd3) with `csr_src_zero_i` = 1 is a pure read and does not trap on a read-only address.
- R6: A CSR-class instruction traps when `priv_i` is numerically less than address bits [9:8]; privilege encodings are user 2'b00, supervisor 2'b01, machine 2'b11.
- R7: `cause_o` is 2 whenever `trap_o` is 1 and 0 whenever `trap_o` is 0.
- R8: Classes other than CSR (`op_class_i` 2'd0 and 2'd3) ignore the CSR address, operation and source inputs, and class 2'd0 ignores `tw_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_class_i | input | 2 | Instruction class: 0 other, 1 CSR access, 2 WFI, 3 other |
| fp_regs_i | input | 1 | Instruction reads or writes floating-point registers |
| csr_addr_i | input | 12 | CSR address field |
| csr_op_i | input | 2 | CSR operation: 0/1 swap, 2 set bits, 3 clear bits |
| csr_src_zero_i | input | 1 | Source register is x0 or immediate is zero |
| priv_i | input | 2 | Current privilege level |
| fs_i | input | 2 | Floating-point enable state, 2'b00 is off |
| tw_i | input | 1 | Wait-timeout bit of the machine status register |
| trap_o | output | 1 | Illegal-instruction exception required |
| cause_o | output | 6 | Exception cause code, 2 on trap |

## Verification
The hardest situations are those where several rules meet on one instruction: a read-only, machine-level CSR read by set-with-zero-source from user mode must still trap through the privilege rule even though the read-only rule is silenced, and a floating-point CSR must trap with the unit off even for a pure read. The stimulus builds these overlaps deliberately, and also sweeps every privilege level against every CSR level field so the ordering of the comparison is covered at each boundary.

// File: rtl/priv_trap_pkg.sv
package priv_trap_pkg;
  localparam int unsigned PRIV_W = 2;
  localparam int unsigned CLASS_W = 2;

  typedef enum logic [PRIV_W-1:0] {
    PRIV_USER  = 2'b00,
    PRIV_SUPER = 2'b01,
    PRIV_RSVD  = 2'b10,
    PRIV_MACH  = 2'b11
  } priv_e;

  typedef enum logic [CLASS_W-1:0] {
    CLS_OTHER = 2'd0,
    CLS_CSR   = 2'd1,
    CLS_WFI   = 2'd2,
    CLS_SPARE = 2'd3
  } op_class_e;

  typedef enum logic [1:0] {
    CSROP_NONE  = 2'd0,
    CSROP_SWAP  = 2'd1,
    CSROP_SET   = 2'd2,
    CSROP_CLEAR = 2'd3
  } csr_op_e;

  localparam logic [1:0] FS_OFF = 2'b00;
  localparam int unsigned ILLEGAL_INSN_CAUSE = 2;
endpackage

// File: rtl/fp_gate.sv
module fp_gate
  import priv_trap_pkg::*;
#(
  parameter int unsigned CSR_AW       = 12,
  parameter int unsigned FP_CSR_FIRST = 1,
  parameter int unsigned FP_CSR_LAST  = 3
) (
  input  logic              is_csr_i,
  input  logic              fp_regs_i,
  input  logic [CSR_AW-1:0] csr_addr_i,
  input  logic [1:0]        fs_i,
  output logic              reg_trap_o,
  output logic              csr_trap_o
);
  localparam logic [CSR_AW-1:0] FIRST_A = CSR_AW'(FP_CSR_FIRST);
  localparam logic [CSR_AW-1:0] LAST_A  = CSR_AW'(FP_CSR_LAST);

  logic fpu_off;
  logic fp_csr_hit;

  assign fpu_off    = (fs_i == FS_OFF);
  assign fp_csr_hit = (csr_addr_i >= FIRST_A) && (csr_addr_i <= LAST_A);
  assign reg_trap_o = fp_regs_i && fpu_off;
  assign csr_trap_o = is_csr_i && fp_csr_hit && fpu_off;
endmodule

// File: rtl/csr_gate.sv
module csr_gate
  import priv_trap_pkg::*;
#(
  parameter int unsigned CSR_AW = 12
) (
  input  logic              is_csr_i,
  input  logic [CSR_AW-1:0] csr_addr_i,
  input  logic [1:0]        csr_op_i,
  input  logic              csr_src_zero_i,
  input  logic [PRIV_W-1:0] priv_i,
  output logic              ro_trap_o,
  output logic              lvl_trap_o
);
  // access bits sit at the top of the address, level bits just below
  localparam int unsigned RO_HI  = CSR_AW - 1;
  localparam int unsigned RO_LO  = CSR_AW - 2;
  localparam int unsigned LVL_HI = CSR_AW - 3;
  localparam int unsigned LVL_LO = CSR_AW - 4;

  logic            read_only;
  logic            writes;
  logic [PRIV_W-1:0] need_lvl;

  assign read_only = &csr_addr_i[RO_HI:RO_LO];
  assign need_lvl  = csr_addr_i[LVL_HI:LVL_LO];

  always_comb begin
    unique case (csr_op_e'(csr_op_i))
      CSROP_SET, CSROP_CLEAR: writes = !csr_src_zero_i;
      default:                writes = 1'b1;
    endcase
  end

  assign ro_trap_o  = is_csr_i && read_only && writes;
  assign lvl_trap_o = is_csr_i && (priv_i < need_lvl);
endmodule

// File: rtl/wfi_gate.sv
module wfi_gate
  import priv_trap_pkg::*;
(
  input  logic              is_wfi_i,
  input  logic              tw_i,
  input  logic [PRIV_W-1:0] priv_i,
  output logic              trap_o
);
  assign trap_o = is_wfi_i && tw_i && (priv_i != PRIV_MACH);
endmodule

// File: rtl/priv_trap_chk.sv
module priv_trap_chk
  import priv_trap_pkg::*;
#(
  parameter int unsigned CSR_AW  = 12,
  parameter int unsigned CAUSE_W = 6
) (
  input  logic [1:0]         op_class_i,
  input  logic               fp_regs_i,
  input  logic [CSR_AW-1:0]  csr_addr_i,
  input  logic [1:0]         csr_op_i,
  input  logic               csr_src_zero_i,
  input  logic [1:0]         priv_i,
  input  logic [1:0]         fs_i,
  input  logic               tw_i,
  output logic               trap_o,
  output logic [CAUSE_W-1:0] cause_o
);
  localparam logic [CAUSE_W-1:0] ILL_CAUSE = CAUSE_W'(ILLEGAL_INSN_CAUSE);

  logic is_csr, is_wfi;
  logic fp_reg_trap, fp_csr_trap, ro_trap, lvl_trap, wfi_trap;

  assign is_csr = (op_class_e'(op_class_i) == CLS_CSR);
  assign is_wfi = (op_class_e'(op_class_i) == CLS_WFI);

  fp_gate #(.CSR_AW(CSR_AW)) u_fp (
    .is_csr_i   (is_csr),
    .fp_regs_i  (fp_regs_i),
    .csr_addr_i (csr_addr_i),
    .fs_i       (fs_i),
    .reg_trap_o (fp_reg_trap),
    .csr_trap_o (fp_csr_trap)
  );

  csr_gate #(.CSR_AW(CSR_AW)) u_csr (
    .is_csr_i       (is_csr),
    .csr_addr_i     (csr_addr_i),
    .csr_op_i       (csr_op_i),
    .csr_src_zero_i (csr_src_zero_i),
    .priv_i         (priv_i),
    .ro_trap_o      (ro_trap),
    .lvl_trap_o     (lvl_trap)
  );

  wfi_gate u_wfi (
    .is_wfi_i (is_wfi),
    .tw_i     (tw_i),
    .priv_i   (priv_i),
    .trap_o   (wfi_trap)
  );

  assign trap_o  = fp_reg_trap | fp_csr_trap | ro_trap | lvl_trap | wfi_trap;
  assign cause_o = trap_o ? ILL_CAUSE : '0;

  always_comb begin
    // R1
    fp_off_chk: assert (!(fp_reg_trap || fp_csr_trap) || fs_i == FS_OFF)
      else $error("fp trap with unit enabled");
    // R3
    wfi_mach_chk: assert (!wfi_trap || (priv_i != PRIV_MACH && tw_i))
      else $error("wfi trap in machine mode or tw clear");
    // R5
    ro_read_chk: assert (!(ro_trap && csr_src_zero_i &&
                           (csr_op_i == CSROP_SET || csr_op_i == CSROP_CLEAR)))
      else $error("read-only trap on pure read");
    // R6
    mach_lvl_chk: assert (!(lvl_trap && priv_i == PRIV_MACH))
      else $error("level trap in machine mode");
    // R8
    class_chk: assert (is_csr || !(ro_trap || lvl_trap || fp_csr_trap))
      else $error("csr trap on non-csr class");
  end
endmodule

// File: tb/priv_trap_chk_test.sv
module priv_trap_chk_test;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic  exp;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic [1:0]  op_class = '0;
  logic        fp_regs = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [1:0]  csr_op = '0;
  logic        src_zero = 1'b0;
  logic [1:0]  priv = '0;
  logic [1:0]  fs = '0;
  logic        tw = 1'b0;
  logic        trap;
  logic [5:0]  cause;

  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  priv_trap_chk uut (
    .op_class_i     (op_class),
    .fp_regs_i      (fp_regs),
    .csr_addr_i     (csr_addr),
    .csr_op_i       (csr_op),
    .csr_src_zero_i (src_zero),
    .priv_i         (priv),
    .fs_i           (fs),
    .tw_i           (tw),
    .trap_o         (trap),
    .cause_o        (cause)
  );

  task automatic drive(input logic [1:0] c, input logic f, input logic [11:0] a,
                       input logic [1:0] o, input logic z, input logic [1:0] p,
                       input logic [1:0] s, input logic t, input logic e,
                       input string tag);
    exp_t it;
    @(negedge clk);
    op_class = c; fp_regs = f; csr_addr = a; csr_op = o;
    src_zero = z; priv = p; fs = s; tw = t;
    it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: results settle half a period after the negedge drive
  always @(posedge clk) begin
    if (sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      checks++;
      if (trap !== it.exp) begin
        errors++;
        $display("FAIL %s trap actual=%0b expected=%0b", it.tag, trap, it.exp);
      end
      checks++;
      if (cause !== (it.exp ? 6'd2 : 6'd0)) begin
        errors++;
        $display("FAIL R7 (%s) cause actual=%0d expected=%0d", it.tag, cause,
                 it.exp ? 2 : 0);
      end
    end
  end

  initial begin
    // idle inputs: class other, user, fs off but no fp use
    drive(2'd0, 0, 12'h000, 2'd0, 0, 2'b00, 2'b00, 0, 0, "R8 idle");
    // R1
    drive(2'd0, 1, 12'h000, 2'd0, 0, 2'b11, 2'b00, 0, 1, "R1 fp off");
    for (int s = 1; s < 4; s++)
      drive(2'd0, 1, 12'h000, 2'd0, 0, 2'b00, 2'(s), 0, 0, "R1 fp on");
    // R2 fp csr reads and writes with unit off, machine mode
    drive(2'd1, 0, 12'h001, 2'd2, 1, 2'b11, 2'b00, 0, 1, "R2 fflags read off");
    drive(2'd1, 0, 12'h003, 2'd1, 0, 2'b11, 2'b00, 0, 1, "R2 fcsr write off");
    drive(2'd1, 0, 12'h002, 2'd1, 0, 2'b00, 2'b01, 0, 0, "R2 frm write on");
    drive(2'd1, 0, 12'h004, 2'd1, 0, 2'b00, 2'b00, 0, 0, "R2 outside range");
    drive(2'd0, 0, 12'h001, 2'd1, 0, 2'b00, 2'b00, 0, 0, "R2 R8 non-csr class");
    // R3
    drive(2'd2, 0, 12'h000, 2'd0, 0, 2'b00, 2'b11, 1, 1, "R3 user tw");
    drive(2'd2, 0, 12'h000, 2'd0, 0, 2'b01, 2'b11, 1, 1, "R3 super tw");
    drive(2'd2, 0, 12'h000, 2'd0, 0, 2'b11, 2'b11, 1, 0, "R3 mach tw");
    drive(2'd2, 0, 12'h000, 2'd0, 0, 2'b00, 2'b11, 0, 0, "R3 user no tw");
    drive(2'd0, 0, 12'h000, 2'd0, 0, 2'b00, 2'b11, 1, 0, "R8 tw ignored");
    // R4 read-only user counter 0xC00 from machine mode
    drive(2'd1, 0, 12'hC00, 2'd1, 1, 2'b11, 2'b11, 0, 1, "R4 swap ro");
    drive(2'd1, 0, 12'hC00, 2'd0, 0, 2'b11, 2'b11, 0, 1, "R4 op0 ro");
    drive(2'd1, 0, 12'hC00, 2'd2, 0, 2'b11, 2'b11, 0, 1, "R4 set nz ro");
    drive(2'd1, 0, 12'hC00, 2'd3, 0, 2'b11, 2'b11, 0, 1, "R4 clear nz ro");
    // R5
    drive(2'd1, 0, 12'hC00, 2'd2, 1, 2'b00, 2'b11, 0, 0, "R5 set zero ro");
    drive(2'd1, 0, 12'hC00, 2'd3, 1, 2'b00, 2'b11, 0, 0, "R5 clear zero ro");
    drive(2'd1, 0, 12'hF11, 2'd2, 1, 2'b00, 2'b11, 0, 1, "R5 R6 mach ro read from user");
    drive(2'd1, 0, 12'hF11, 2'd2, 1, 2'b11, 2'b11, 0, 0, "R5 mach ro read from mach");
    // R6 sweep of privilege against level field, read-write address space
    for (int p = 0; p < 4; p++)
      for (int l = 0; l < 4; l++)
        drive(2'd1, 0, {2'b00, 2'(l), 8'h40}, 2'd1, 0, 2'(p), 2'b11, 0,
              (p < l), "R6 level sweep");
    // R8 spare class ignores csr fields
    drive(2'd3, 0, 12'hF11, 2'd1, 0, 2'b00, 2'b11, 0, 0, "R8 spare class");
    @(negedge clk);
    @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done == 1);
      begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule